// File: doc/BRIEF.md
# Two-Wire Configuration Word Receiver

This block is a receive-only slave on a two-wire serial bus (I2C). It holds one 16-bit configuration word, split into three fields: a 4-bit octave code, a 10-bit fine frequency code and a 2-bit output mode. A bus master sets the word with one write transaction. The transaction carries a START, the slave address with a write bit, a high data byte and a low data byte, then a STOP. The slave acknowledges the address and each of the two data bytes. Each data byte is stored in its own half of the word as soon as it is acknowledged.

A system clock oversamples both bus lines. Each line goes through a synchronizer and then a short majority-free glitch filter, which changes its output only after several equal samples. The slave never drives a logic one. Its single output `sda_oe` is an open-drain pull-down enable. The pad logic pulls SDA low while `sda_oe` is high.

The fields are plain level outputs. They change only in the cycle in which the matching data byte is acknowledged. The block has no flow control at its edge, so there is no valid/ready pair and no back-pressure rule.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, `oct_code`, `fine_code` and `out_mode` are all zero and `sda_oe` is low.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. Both lines idle high.
- R3: The slave acknowledges an address byte in these two cases only:
  - `addr_strap`=0 and the byte is 0x2E (address 0010111, write bit 0);
  - `addr_strap`=1 and the byte is 0x2C (address 0010110, write bit 0).
  The byte is sent MSB first. To acknowledge, the slave holds SDA low through the high phase of the ninth clock.
- R4: An address byte with a wrong address or with the read bit (1) gets no acknowledge. The slave then ignores the bus until the next START. Data bytes sent after such an address get no acknowledge and leave the fields unchanged.
- R5: The first data byte after a matching address is acknowledged and stored as word bits [15:8]. The word layout is: `oct_code` = bits [15:12], `fine_code` = bits [11:2], `out_mode` = bits [1:0].
- R6: The second data byte is acknowledged and stored as word bits [7:0].
- R7: Any data byte after the second gets no acknowledge and is discarded. The word keeps the first two bytes.
- R8: A repeated START at any point restarts address reception. A following complete write then takes effect normally.
- R9: A STOP returns the slave to idle. Bytes already stored are kept. A STOP after only the high byte leaves the low half unchanged.
- R10: `sda_oe` is high only during an acknowledge bit. It changes only while the filtered SCL is low. It is low while the master sends data bits.
- R11: A pulse on SCL that lasts fewer clock cycles than `FILT_LEN` has no effect on reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_strap | input | 1 | Strap; the address LSB is its inverse |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| oct_code | output | 4 | Octave field, word bits [15:12] |
| fine_code | output | 10 | Fine code field, word bits [11:2] |
| out_mode | output | 2 | Output mode field, word bits [1:0] |

## Verification
The bench sends every possible address byte with the strap low, and the bytes around the matching address with the strap high. A decoder that forgets to invert the strap, or that ignores the read bit, acknowledges the wrong byte or misses the right one.

It also sends aborted writes:
- a STOP after only the high byte;
- a repeated START in the middle of a write;
- a third data byte.

A slave that clears a half on STOP, keeps counting bytes across a restart, or acknowledges extra bytes ends with the wrong fields or a wrong acknowledge.

Finally, a one-cycle SCL spike during a byte would shift in a phantom bit if the filter were missing or too short. That shows up as a corrupted word.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_RECV = 2'd1,
    BUS_SKIP = 2'd2
  } bus_state_t;

  typedef enum logic [1:0] {
    SLOT_ADDR  = 2'd0,
    SLOT_HIGH  = 2'd1,
    SLOT_LOW   = 2'd2,
    SLOT_EXTRA = 2'd3
  } byte_slot_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/cfg_i2c_filter.sv
module cfg_i2c_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= '1;
      clean  <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)
        clean <= 1'b1;
      else if (~|hist_q)
        clean <= 1'b0;
    end
  end
endmodule

// File: rtl/cfg_i2c_cond.sv
module cfg_i2c_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    scl_rise  = scl & ~scl_q;
    scl_fall  = ~scl & scl_q;
    start_det = scl & scl_q & sda_q & ~sda;
    stop_det  = scl & scl_q & ~sda_q & sda;
  end
endmodule

// File: rtl/cfg_i2c_engine.sv
module cfg_i2c_engine
  import cfg_i2c_pkg::*;
#(
  parameter logic [5:0] ADDR_FIXED = 6'b001011,
  parameter int         WORD_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda,
  input  logic              strap,
  output logic              sda_oe,
  output logic              idle,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  bus_state_t        state_q;
  byte_slot_t        slot_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ack_q;
  logic [BYTE_W-1:0] shreg_q;
  logic              addr_ok;

  assign addr_ok = (shreg_q[BYTE_W-1:1] == {ADDR_FIXED, ~strap}) && !shreg_q[0];
  assign idle    = (state_q == BUS_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BUS_IDLE;
      slot_q  <= SLOT_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      shreg_q <= '0;
      sda_oe  <= 1'b0;
      word    <= '0;
    end else if (start_det) begin
      state_q <= BUS_RECV;
      slot_q  <= SLOT_ADDR;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state_q <= BUS_IDLE;
      ack_q   <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (state_q == BUS_RECV) begin
      if (scl_rise && !ack_q && cnt_q != LAST_BIT) begin
        shreg_q <= {shreg_q[BYTE_W-2:0], sda};
        cnt_q   <= cnt_q + 1'b1;
      end else if (scl_fall && ack_q) begin
        sda_oe <= 1'b0;
        ack_q  <= 1'b0;
        cnt_q  <= '0;
        if (slot_q != SLOT_EXTRA)
          slot_q <= byte_slot_t'(slot_q + 2'd1);
      end else if (scl_fall && cnt_q == LAST_BIT) begin
        case (slot_q)
          SLOT_ADDR: begin
            if (addr_ok) begin
              sda_oe <= 1'b1;
              ack_q  <= 1'b1;
            end else begin
              state_q <= BUS_SKIP;
            end
          end
          SLOT_HIGH: begin
            word[WORD_W-1:BYTE_W] <= shreg_q;
            sda_oe <= 1'b1;
            ack_q  <= 1'b1;
          end
          SLOT_LOW: begin
            word[BYTE_W-1:0] <= shreg_q;
            sda_oe <= 1'b1;
            ack_q  <= 1'b1;
          end
          default: begin
            ack_q <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter logic [5:0] ADDR_FIXED  = 6'b001011,
  parameter int         OCT_W       = 4,
  parameter int         FINE_W      = 10,
  parameter int         MODE_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_strap,
  output logic              sda_oe,
  output logic [OCT_W-1:0]  oct_code,
  output logic [FINE_W-1:0] fine_code,
  output logic [MODE_W-1:0] out_mode
);
  localparam int WORD_W = OCT_W + FINE_W + MODE_W;

  logic [1:0]        raw_bus;
  logic [1:0]        clean_bus;
  logic              scl_f, sda_f;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              st_idle;
  logic [WORD_W-1:0] cfg_word;

  assign raw_bus = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    cfg_i2c_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_bus[g]),
      .clean(clean_bus[g])
    );
  end

  assign scl_f = clean_bus[0];
  assign sda_f = clean_bus[1];

  cfg_i2c_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  cfg_i2c_engine #(
    .ADDR_FIXED(ADDR_FIXED),
    .WORD_W    (WORD_W)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda      (sda_f),
    .strap    (addr_strap),
    .sda_oe   (sda_oe),
    .idle     (st_idle),
    .word     (cfg_word)
  );

  assign oct_code  = cfg_word[WORD_W-1 -: OCT_W];
  assign fine_code = cfg_word[MODE_W +: FINE_W];
  assign out_mode  = cfg_word[MODE_W-1:0];
endmodule

// File: rtl/cfg_i2c_checker.sv
module cfg_i2c_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_f,
  input logic              sda_oe,
  input logic [WORD_W-1:0] cfg_word,
  input logic              st_idle,
  input logic              stop_det
);
  // R10: the pull-down only toggles while the filtered clock is low
  assert_oe_edge_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f);

  // R10: no pull-down while the receiver is idle
  assert_oe_not_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> !st_idle);

  // R5 / R6: the word only moves together with an acknowledge
  assert_word_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word != $past(cfg_word)) |-> sda_oe);

  // R9: a STOP always lands the receiver in idle
  assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> st_idle);
endmodule

bind cfg_i2c_slave cfg_i2c_checker #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .scl_f   (scl_f),
  .sda_oe  (sda_oe),
  .cfg_word(cfg_word),
  .st_idle (st_idle),
  .stop_det(stop_det)
);

// File: tb/cfg_i2c_slave_test.sv
module cfg_i2c_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic strap = 1'b0;
  logic sda_oe;
  logic [3:0] oct_code;
  logic [9:0] fine_code;
  logic [1:0] out_mode;
  logic sda_line;

  int n_tests = 0;
  int n_fail = 0;
  int drive_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  cfg_i2c_slave uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .addr_strap(strap),
    .sda_oe    (sda_oe),
    .oct_code  (oct_code),
    .fine_code (fine_code),
    .out_mode  (out_mode)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] cur_word();
    return {oct_code, fine_code, out_mode};
  endfunction

  task automatic bus_start;
    m_sda = 1'b1; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(Q);
    m_sda = 1'b0; wait_cyc(Q);
    m_scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(Q);
    m_sda = 1'b1; wait_cyc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      if (glitch && i == 4) begin
        wait_cyc(3);
        m_scl = 1'b1; wait_cyc(1);
        m_scl = 1'b0; wait_cyc(Q - 4);
      end else begin
        wait_cyc(Q);
      end
      m_scl = 1'b1; wait_cyc(Q);
      if (sda_line !== m_sda) drive_err++;
      wait_cyc(Q);
      m_scl = 1'b0; wait_cyc(Q);
    end
    m_sda = 1'b1; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(Q);
    ack = !sda_line;
    wait_cyc(Q);
    m_scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic write_word(input logic [7:0] adr, input logic [15:0] w, input bit glitch,
                            output bit a0, output bit a1, output bit a2);
    bus_start;
    send_byte(adr, 1'b0, a0);
    send_byte(w[15:8], glitch, a1);
    send_byte(w[7:0], glitch, a2);
    bus_stop;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit a0, a1, a2, a3;
    logic [15:0] w, exp_w;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1: reset state
    chk(cur_word() == 16'h0, "R1 word after reset", cur_word(), 0);
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);

    // R2/R3/R4: every address byte, strap low
    for (int b = 0; b < 256; b++) begin
      bus_start;
      send_byte(8'(b), 1'b0, a0);
      bus_stop;
      chk(a0 == (b == 8'h2E), "R3 R4 addr ack strap0", a0, b == 8'h2E);
    end
    // R3: strap high flips the address LSB
    strap = 1'b1;
    for (int b = 8'h2C; b <= 8'h2F; b++) begin
      bus_start;
      send_byte(8'(b), 1'b0, a0);
      bus_stop;
      chk(a0 == (b == 8'h2C), "R3 addr ack strap1", a0, b == 8'h2C);
    end
    write_word(8'h2C, 16'hC3A5, 1'b0, a0, a1, a2);
    chk(cur_word() == 16'hC3A5, "R3 write with strap1", cur_word(), 16'hC3A5);
    strap = 1'b0;

    // R5/R6: word sweep with fields checked arithmetically
    for (int k = 0; k < 8; k++) begin
      w = 16'(k * 16'h2B5D + 16'h0137);
      write_word(8'h2E, w, 1'b0, a0, a1, a2);
      chk(a1 && a2, "R5 R6 data acks", {a1, a2}, 3);
      chk(oct_code == 4'(w >> 12), "R5 octave field", oct_code, w >> 12);
      chk(fine_code == 10'((w >> 2) & 16'h3FF), "R5 R6 fine field", fine_code, (w >> 2) & 16'h3FF);
      chk(out_mode == 2'(w & 16'h3), "R6 mode field", out_mode, w & 3);
    end
    exp_w = w;

    // R4: read bit and wrong address are ignored
    write_word(8'h2F, 16'h1111, 1'b0, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R4 read bit no acks", {a0, a1, a2}, 0);
    chk(cur_word() == exp_w, "R4 read leaves word", cur_word(), exp_w);
    write_word(8'h2C, 16'h2222, 1'b0, a0, a1, a2);
    chk(!a0 && !a1 && !a2, "R4 mismatch no acks", {a0, a1, a2}, 0);
    chk(cur_word() == exp_w, "R4 mismatch leaves word", cur_word(), exp_w);

    // R7: third data byte
    bus_start;
    send_byte(8'h2E, 1'b0, a0);
    send_byte(8'h5A, 1'b0, a1);
    send_byte(8'h69, 1'b0, a2);
    send_byte(8'hFF, 1'b0, a3);
    bus_stop;
    chk(a0 && a1 && a2 && !a3, "R7 acks then nack", {a0, a1, a2, a3}, 4'hE);
    chk(cur_word() == 16'h5A69, "R7 extra byte discarded", cur_word(), 16'h5A69);

    // R8: repeated start mid-write
    bus_start;
    send_byte(8'h2E, 1'b0, a0);
    send_byte(8'hA5, 1'b0, a1);
    bus_start;
    send_byte(8'h2E, 1'b0, a0);
    send_byte(8'h3C, 1'b0, a1);
    send_byte(8'h96, 1'b0, a2);
    bus_stop;
    chk(a0 && a1 && a2, "R8 acks after restart", {a0, a1, a2}, 7);
    chk(cur_word() == 16'h3C96, "R8 restart word", cur_word(), 16'h3C96);

    // R9: stop after only the high byte
    bus_start;
    send_byte(8'h2E, 1'b0, a0);
    send_byte(8'h71, 1'b0, a1);
    bus_stop;
    wait_cyc(Q);
    chk(cur_word() == 16'h7196, "R9 partial write keeps low half", cur_word(), 16'h7196);
    chk(sda_oe == 1'b0, "R9 R10 released after stop", sda_oe, 0);

    // R11: one-cycle SCL spikes during both data bytes
    write_word(8'h2E, 16'hB4E1, 1'b1, a0, a1, a2);
    chk(a0 && a1 && a2, "R11 acks with spikes", {a0, a1, a2}, 7);
    chk(cur_word() == 16'hB4E1, "R11 spike ignored", cur_word(), 16'hB4E1);

    // R10: no pull-down seen during any data bit
    chk(drive_err == 0, "R10 no drive on data bits", drive_err, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule